// File: doc/BRIEF.md
# Flat Page Table Translation Walker

This block converts a 32-bit virtual address into a physical address using a single, flat page table kept in memory. Each request carries an address and an access kind (read, write or execute). The upper twenty bits of the address select one 32-bit entry in the table. The table's start address comes from a base register that only privileged (kernel-mode) writes can change. The walker reads that entry over a simple request/response memory port. It then checks the entry's valid flag and its permission flags, and finishes with a one-cycle completion pulse. The pulse carries either a physical address or exactly one of two fault flags.

Requests arrive through a valid/ready handshake and are processed one at a time. The base value is sampled when a request is accepted. The dirty flag in the entry is carried in memory but plays no part in translation. Fault handling, caching of translations and deeper table hierarchies are left to the surrounding system.

Top module: `page_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, reqReady is 1, memReqValid is 0 and doneValid is 0.
- R2: The base register takes baseWrData at a clock edge only when baseWrEn and kernelMode are both 1. A write with kernelMode at 0 leaves the base unchanged, which shows in the entry address of the next walk.
- R3: Each walk issues exactly one memory read, at address base + VA[31:12] * 4. memReqValid rises the cycle after the request is accepted and stays high, with a stable address, until memReqReady is seen.
- R4: reqReady is 1 only while no walk is in progress, so a request held high during a walk is not accepted a second time.
- R5: A base write during a walk does not change the entry address of that walk. The base in use is the one present at request acceptance.
- R6: The entry's bit 0 is the valid flag. When it is 0, the result shows donePageFault=1, donePermFault=0 and donePaddr=0.
- R7: Access encoding is 0=read, 1=write, 2=execute and 3=reserved. These are checked against entry bits 1 (read), 2 (write) and 3 (execute). Code 3 is never allowed. A valid entry that lacks the needed bit gives donePermFault=1, donePageFault=0 and donePaddr=0.
- R8: A valid, permitted entry gives donePaddr = {entry[31:12], VA[11:0]} with both fault flags at 0. The dirty flag (bit 4) and bits 11:5 have no effect.
- R9: doneValid is a one-cycle pulse in the cycle after the memory response is taken. reqReady returns in the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| kernelMode | input | 1 | Privilege qualifier for base register writes |
| baseWrEn | input | 1 | Base register write strobe |
| baseWrData | input | 32 | New table base address |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker can take a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory takes the read request |
| memReqAddr | output | 32 | Entry address |
| memRespValid | input | 1 | Entry data returned |
| memRespData | input | 32 | Page table entry |
| doneValid | output | 1 | One-cycle completion pulse |
| donePaddr | output | 32 | Translated physical address, 0 on fault |
| donePageFault | output | 1 | Entry was not valid |
| donePermFault | output | 1 | Access kind not permitted |

## Verification
An accepted request is due on memReqValid one cycle after the accepting edge. The walk moves on at the edge where memReqReady is seen. The completion pulse is due one cycle after the edge that takes memRespValid, and reqReady comes back one cycle after the pulse. The bench keeps a behavioural model that advances on the same edges from the sampled inputs. At every falling edge it compares the handshake outputs, the entry address and the completion fields against that model, so each result is checked in exactly the cycle it becomes due. A memory responder with programmable stall and latency shifts those cycles, and the model follows them.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_READ_BIT  = 1;
  localparam int PTE_WRITE_BIT = 2;
  localparam int PTE_EXEC_BIT  = 3;
  localparam int PTE_DIRTY_BIT = 4;

  typedef struct packed {
    logic captureReq;
    logic captureEntry;
  } walkStrobe_t;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRespValid,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        doneValid,
  output walkStrobe_t strobe
);

  typedef enum logic [1:0] {IDLE, READ_PTE, WAIT_RESP, DONE} state_e;

  state_e state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      IDLE:      if (reqValid)     nextState = READ_PTE;
      READ_PTE:  if (memReqReady)  nextState = WAIT_RESP;
      WAIT_RESP: if (memRespValid) nextState = DONE;
      DONE:                        nextState = IDLE;
      default:                     nextState = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE;
    else       state <= nextState;
  end

  assign reqReady            = (state == IDLE);
  assign memReqValid         = (state == READ_PTE);
  assign doneValid           = (state == DONE);
  assign strobe.captureReq   = (state == IDLE) && reqValid;
  assign strobe.captureEntry = (state == WAIT_RESP) && memRespValid;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid && reqReady); // R9

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureReq |=> !reqReady && memReqValid); // R4

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 12,
  parameter int PTE_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic              kernelMode,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic              memReqValid,
  input  logic              memReqReady,
  input  logic [PTE_W-1:0]  memRespData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [PTE_W-1:0]  paddr,
  output logic              pageFault,
  output logic              permFault
);

  localparam int VPN_W     = ADDR_W - OFFSET_W;
  localparam int PTE_SHIFT = $clog2(PTE_W / 8);

  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] walkBase;
  logic [ADDR_W-1:0] vaReg;
  access_e           accReg;
  logic [VPN_W-1:0]  vpn;
  logic              entryValid;
  logic              permOk;

  always_ff @(posedge clk) begin
    if (!rstN)                        baseReg <= '0;
    else if (baseWrEn && kernelMode)  baseReg <= baseWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      walkBase <= '0;
      vaReg    <= '0;
      accReg   <= ACC_READ;
    end else if (strobe.captureReq) begin
      walkBase <= baseReg;
      vaReg    <= reqVaddr;
      accReg   <= access_e'(reqAccess);
    end
  end

  assign vpn        = vaReg[ADDR_W-1:OFFSET_W];
  assign memReqAddr = walkBase + (ADDR_W'(vpn) << PTE_SHIFT);
  assign entryValid = memRespData[PTE_VALID_BIT];

  always_comb begin
    case (accReg)
      ACC_READ:  permOk = memRespData[PTE_READ_BIT];
      ACC_WRITE: permOk = memRespData[PTE_WRITE_BIT];
      ACC_EXEC:  permOk = memRespData[PTE_EXEC_BIT];
      default:   permOk = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paddr     <= '0;
      pageFault <= 1'b0;
      permFault <= 1'b0;
    end else if (strobe.captureEntry) begin
      pageFault <= !entryValid;
      permFault <= entryValid && !permOk;
      paddr     <= (entryValid && permOk)
                   ? {memRespData[PTE_W-1:OFFSET_W], vaReg[OFFSET_W-1:0]}
                   : '0;
    end
  end

  AST_BASE_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    !(baseWrEn && kernelMode) |=> $stable(baseReg)); // R2

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr)); // R5

endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 12,
  parameter int PTE_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              kernelMode,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [1:0]        reqAccess,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRespValid,
  input  logic [PTE_W-1:0]  memRespData,
  output logic              doneValid,
  output logic [PTE_W-1:0]  donePaddr,
  output logic              donePageFault,
  output logic              donePermFault
);

  walkStrobe_t strobe;

  ptw_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .doneValid    (doneValid),
    .strobe       (strobe)
  );

  ptw_datapath #(
    .ADDR_W   (ADDR_W),
    .OFFSET_W (OFFSET_W),
    .PTE_W    (PTE_W)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .kernelMode  (kernelMode),
    .baseWrEn    (baseWrEn),
    .baseWrData  (baseWrData),
    .reqVaddr    (reqVaddr),
    .reqAccess   (reqAccess),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memRespData (memRespData),
    .memReqAddr  (memReqAddr),
    .paddr       (donePaddr),
    .pageFault   (donePageFault),
    .permFault   (donePermFault)
  );

  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !(donePageFault && donePermFault)); // R7

  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && (donePageFault || donePermFault) |-> donePaddr == '0); // R6

endmodule

// File: tb/test_page_walker.sv
`timescale 1ns/1ps
module test_page_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        kernelMode = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRespValid = 1'b0;
  logic [31:0] memRespData = '0;
  logic        doneValid;
  logic [31:0] donePaddr;
  logic        donePageFault;
  logic        donePermFault;

  int total = 0;
  int bad = 0;
  string addrTag = "R3";

  // responder settings
  logic [31:0] pteValue = '0;
  int stallLeft = 0;
  int memLat = 1;
  int pend = 0;
  bit inFlight = 1'b0;
  int reads = 0;

  // reference model state
  int          mPhase;
  logic [31:0] mBase, mWalkBase, mVa, mPa;
  logic [1:0]  mAcc;
  logic        mPf, mPerm;

  page_walker i_page_walker (
    .clk (clk), .rstN (rstN), .kernelMode (kernelMode),
    .baseWrEn (baseWrEn), .baseWrData (baseWrData),
    .reqValid (reqValid), .reqReady (reqReady),
    .reqVaddr (reqVaddr), .reqAccess (reqAccess),
    .memReqValid (memReqValid), .memReqReady (memReqReady),
    .memReqAddr (memReqAddr), .memRespValid (memRespValid),
    .memRespData (memRespData), .doneValid (doneValid),
    .donePaddr (donePaddr), .donePageFault (donePageFault),
    .donePermFault (donePermFault)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [33:0] refOutcome(input logic [31:0] pte, input logic [31:0] va,
                                             input logic [1:0] acc);
    logic allowed;
    if (acc == 2'd0)      allowed = pte[1];
    else if (acc == 2'd1) allowed = pte[2];
    else if (acc == 2'd2) allowed = pte[3];
    else                  allowed = 1'b0;
    if (!pte[0])       return {1'b1, 1'b0, 32'h0};
    else if (!allowed) return {1'b0, 1'b1, 32'h0};
    else               return {1'b0, 1'b0, pte[31:12], va[11:0]};
  endfunction

  // behavioural reference, advanced on the same edges as the design
  always @(posedge clk) begin
    if (!rstN) begin
      mPhase <= 0; mBase <= '0; mWalkBase <= '0; mVa <= '0; mAcc <= '0;
      mPa <= '0; mPf <= 1'b0; mPerm <= 1'b0;
    end else begin
      if (baseWrEn && kernelMode) mBase <= baseWrData;
      if (mPhase == 0) begin
        if (reqValid) begin
          mPhase <= 1; mWalkBase <= mBase; mVa <= reqVaddr; mAcc <= reqAccess;
        end
      end else if (mPhase == 1) begin
        if (memReqReady) mPhase <= 2;
      end else if (mPhase == 2) begin
        if (memRespValid) begin
          mPhase <= 3;
          {mPf, mPerm, mPa} <= refOutcome(memRespData, mVa, mAcc);
        end
      end else begin
        mPhase <= 0;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R4 reqReady", {31'b0, reqReady}, {31'b0, mPhase == 0});
      chk("R3 memReqValid", {31'b0, memReqValid}, {31'b0, mPhase == 1});
      if (mPhase == 1)
        chk({addrTag, " memReqAddr"}, memReqAddr, mWalkBase + {mVa[31:12], 2'b00});
      chk("R9 doneValid", {31'b0, doneValid}, {31'b0, mPhase == 3});
      if (mPhase == 3) begin
        chk("R8 donePaddr", donePaddr, mPa);
        chk("R6 donePageFault", {31'b0, donePageFault}, {31'b0, mPf});
        chk("R7 donePermFault", {31'b0, donePermFault}, {31'b0, mPerm});
      end
    end
  end

  // memory responder with programmable stall and latency
  always @(negedge clk) begin
    if (!rstN) begin
      memReqReady = 1'b0; memRespValid = 1'b0; inFlight = 1'b0; pend = 0;
    end else begin
      if (memRespValid) memRespValid = 1'b0;
      if (memReqReady) begin
        memReqReady = 1'b0; inFlight = 1'b1; pend = memLat; reads++;
      end else if (inFlight) begin
        pend--;
        if (pend <= 0) begin
          memRespValid = 1'b1; memRespData = pteValue; inFlight = 1'b0;
        end
      end else if (memReqValid) begin
        if (stallLeft > 0) stallLeft--;
        else memReqReady = 1'b1;
      end
    end
  end

  task automatic writeBase(input logic [31:0] val, input logic kern);
    @(negedge clk);
    baseWrEn = 1'b1; kernelMode = kern; baseWrData = val;
    @(negedge clk);
    baseWrEn = 1'b0; kernelMode = 1'b0;
  endtask

  task automatic doWalk(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] pte,
                        input int stall, input int lat, input bit holdReq, input bit midBase);
    @(negedge clk);
    pteValue = pte; stallLeft = stall; memLat = lat; reads = 0;
    reqVaddr = va; reqAccess = acc; reqValid = 1'b1;
    @(negedge clk);
    if (!holdReq) reqValid = 1'b0;
    if (midBase) begin
      baseWrEn = 1'b1; kernelMode = 1'b1; baseWrData = 32'hDEAD_0000;
      @(negedge clk);
      baseWrEn = 1'b0; kernelMode = 1'b0;
    end
    while (!doneValid) @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R3 one read per walk", reads, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reqReady in reset", {31'b0, reqReady}, 32'd1);
    chk("R1 memReqValid in reset", {31'b0, memReqValid}, 32'd0);
    chk("R1 doneValid in reset", {31'b0, doneValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reqReady after reset", {31'b0, reqReady}, 32'd1);

    writeBase(32'h0010_0000, 1'b1);
    // R8 plain successful read
    doWalk(32'h1234_5ABC, 2'd0, 32'hABCDE_003, 0, 1, 1'b0, 1'b0);
    // R6 invalid entry with all permissions set
    doWalk(32'h0000_1FFF, 2'd0, 32'hFFFFF_00E, 1, 2, 1'b0, 1'b0);
    // R7 write denied, then allowed
    doWalk(32'h0004_2010, 2'd1, 32'h00042_003, 0, 1, 1'b0, 1'b0);
    doWalk(32'h0004_2010, 2'd1, 32'h00042_005, 0, 1, 1'b0, 1'b0);
    // R7 execute allowed, execute denied, reserved code denied
    doWalk(32'h0000_0000, 2'd2, 32'h00043_009, 0, 1, 1'b0, 1'b0);
    doWalk(32'h8000_0777, 2'd2, 32'h00043_007, 0, 3, 1'b0, 1'b0);
    doWalk(32'h8000_0777, 2'd3, 32'h00043_00F, 0, 1, 1'b0, 1'b0);
    // R2 non-kernel write ignored; top VPN boundary
    writeBase(32'h0800_0000, 1'b0);
    addrTag = "R2";
    doWalk(32'hFFFF_F123, 2'd0, 32'h7FFFF_003, 0, 1, 1'b0, 1'b0);
    // R5 base write mid-walk, R4 request held high, stalls, R8 dirty and spare bits
    addrTag = "R5";
    doWalk(32'h00AB_C321, 2'd0, 32'h12345_FF3, 3, 4, 1'b1, 1'b0);
    doWalk(32'h0055_5444, 2'd0, 32'h54321_FF3, 3, 4, 1'b1, 1'b1);
    addrTag = "R3";
    doWalk(32'h0055_5444, 2'd1, 32'h54321_015, 0, 1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule